// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept or discarded based on its 48-bit destination address. The address arrives one byte per cycle, most significant byte last: the first byte carries a start strobe, and the six bytes may be spread over several cycles with gaps between them. One cycle after the sixth byte, the block presents a single-cycle verdict strobe with an accept flag.

The verdict is drawn from four sources, tried in a fixed order. A copy-all control bit accepts everything. A bank of eight exact-match entries comes next; entry 0 is meant for the station's own unicast address and the others for multicast groups. The all-ones broadcast address is accepted unless a broadcast-disable bit is set. A 64-bin multicast hash table catches group addresses that miss every exact entry, gated by a hash-enable bit.

Software loads the exact entries and the hash table through a single-cycle register write port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset no exact entry is valid, the hash table is all zeros and `verdict_valid` and `verdict_accept` are low. Right after reset only broadcast frames, and any frame while copy-all is set, are accepted.
- R2: Address byte 0 is the byte presented with `da_start`, and bytes 1..5 follow on later `da_valid` cycles. `verdict_valid` is high for exactly one cycle, in the cycle after byte 5 is taken. `verdict_accept` is low whenever `verdict_valid` is low. A new `da_start` in the middle of an address discards the partial address.
- R3: When `ctl_copy_all` is high in the cycle of byte 5, the frame is accepted whatever its address.
- R4: Write addresses 2*k and 2*k+1 (k = 0..7) are the low and high words of exact entry k. The low word holds address bytes 3,2,1,0 in bits 31:24, 23:16, 15:8, 7:0. The high word holds byte 5 in bits 15:8 and byte 4 in bits 7:0. An entry matches only after its high word has been written. A matching valid entry accepts the frame.
- R5: The hash index is 6 bits. The 48 address bits are walked from byte 0 to byte 5, least significant bit first within each byte, and walk bit n is XORed into index bit (n mod 6).
- R6: Write address 16 loads hash table bits 31:0 and write address 17 loads bits 63:32. Index i selects table bit i. Any other write address changes nothing.
- R7: The hash lookup applies only to multicast frames (bit 0 of byte 0 set) that are not broadcast and miss every exact entry. It applies only when `ctl_hash_en` is high, and then the frame is accepted if the selected table bit is 1.
- R8: The all-ones address is accepted when `ctl_bcast_dis` is low. When it is high, that address is dropped unless copy-all is set or a valid exact entry holds it.
- R9: A unicast frame (bit 0 of byte 0 clear) that matches no valid exact entry is dropped when copy-all is low.
- R10: With both hash words set to all ones and hash enabled, every non-broadcast multicast address is accepted.
- R11: After byte 5, further `da_valid` cycles without `da_start` are ignored and produce no verdict. So are `da_valid` cycles without a start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 5 | Register write address (entries 0..15, hash 16..17) |
| cfg_wr_data | input | 32 | Register write data |
| ctl_copy_all | input | 1 | Accept every frame |
| ctl_hash_en | input | 1 | Enable the multicast hash lookup |
| ctl_bcast_dis | input | 1 | Reject the broadcast address |
| da_valid | input | 1 | Address byte present |
| da_start | input | 1 | Marks byte 0 of a new address (with `da_valid`) |
| da_byte | input | 8 | Address byte |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame accepted (qualified by `verdict_valid`) |

## Verification
The assertions assume that `da_start` is only raised together with `da_valid`, and that the control bits are stable and known in the cycle of the sixth byte. The stimulus drives the address and configuration inputs from tasks between clock edges, and it raises the start strobe only on the first byte of an address. A configuration write never shares a cycle with a sixth byte, so each verdict depends only on tables that were already settled. Gaps, restarts and stray bytes are applied on purpose to check the byte-counting assumptions.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HASH_W     = 6;
  localparam int HASH_BINS  = 1 << HASH_W;

  // Index bit k collects address bits k, k+HASH_W, k+2*HASH_W, ...
  function automatic logic [HASH_W-1:0] fold_hash(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    for (int k = 0; k < HASH_W; k++) begin
      h[k] = 1'b0;
      for (int j = k; j < ADDR_W; j += HASH_W) h[k] = h[k] ^ a[j];
    end
    return h;
  endfunction

  function automatic logic is_group(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic is_all_ones(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction
endpackage

// File: rtl/rxaf_addr_capture.sv
module rxaf_addr_capture #(
  parameter int BYTES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               da_valid,
  input  logic               da_start,
  input  logic [7:0]         da_byte,
  output logic               last_byte,
  output logic [8*BYTES-1:0] full_addr
);
  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;
  logic          take;

  assign take = da_valid && (da_start || (cnt_q != '0 && cnt_q < CW'(BYTES)));
  assign pos  = da_start ? '0 : cnt_q;
  assign last_byte = da_valid && !da_start && (cnt_q == CW'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (take) cnt_q <= pos + 1'b1;
  end

  generate
    for (genvar b = 0; b < BYTES - 1; b++) begin : g_hold
      logic [7:0] held_q;
      always_ff @(posedge clk) begin
        if (take && pos == CW'(b)) held_q <= da_byte;
      end
      assign full_addr[8*b +: 8] = held_q;
    end
  endgenerate
  assign full_addr[8*(BYTES-1) +: 8] = da_byte;

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> cnt_q == CW'(BYTES)); // R2
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(BYTES) && !da_start) |=> cnt_q == CW'(BYTES)); // R11
endmodule

// File: rtl/rxaf_exact_bank.sv
module rxaf_exact_bank #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48,
  localparam int EIW    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EIW-1:0]    wr_entry,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit
);
  logic [ENTRIES-1:0] match;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [31:0]        lo_q;
      logic [ADDR_W-33:0] hi_q;
      logic               vld_q;
      logic               sel_lo, sel_hi;

      assign sel_lo = wr_en && !wr_hi && wr_entry == EIW'(i);
      assign sel_hi = wr_en &&  wr_hi && wr_entry == EIW'(i);

      always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else if (sel_hi) vld_q <= 1'b1;
      end
      always_ff @(posedge clk) begin
        if (sel_lo) lo_q <= wr_data;
        if (sel_hi) hi_q <= wr_data[ADDR_W-33:0];
      end

      assign match[i] = vld_q && {hi_q, lo_q} == look_addr;

      AST_VALID_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_q) |-> $past(sel_hi)); // R4
    end
  endgenerate

  assign hit = |match;
endmodule

// File: rtl/rxaf_hash_table.sv
module rxaf_hash_table
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [HASH_W-1:0] bin,
  output logic              bin_set
);
  logic [HASH_BINS-1:0] table_q;

  always_ff @(posedge clk) begin
    if (!rst_n) table_q <= '0;
    else begin
      if (wr_lo) table_q[31:0]  <= wr_data;
      if (wr_hi) table_q[63:32] <= wr_data;
    end
  end

  assign bin     = fold_hash(look_addr);
  assign bin_set = table_q[bin];

  AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_lo) && !$past(wr_hi)) |-> $stable(table_q)); // R6
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int  ENTRIES = 8,
  localparam int CFG_AW  = $clog2(2 * ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [31:0]       cfg_wr_data,
  input  logic              ctl_copy_all,
  input  logic              ctl_hash_en,
  input  logic              ctl_bcast_dis,
  input  logic              da_valid,
  input  logic              da_start,
  input  logic [7:0]        da_byte,
  output logic              verdict_valid,
  output logic              verdict_accept
);
  localparam int EIW = $clog2(ENTRIES);

  logic              last_byte;
  logic [ADDR_W-1:0] cur_addr;
  logic              ent_wr, hash_wr_lo, hash_wr_hi;
  logic              exact_hit, bin_set;
  logic [HASH_W-1:0] bin;
  logic              is_b, is_m;
  logic              why_copy, why_exact, why_bcast, why_hash, accept_c;

  assign ent_wr     = cfg_wr_en && cfg_wr_addr <  CFG_AW'(2 * ENTRIES);
  assign hash_wr_lo = cfg_wr_en && cfg_wr_addr == CFG_AW'(2 * ENTRIES);
  assign hash_wr_hi = cfg_wr_en && cfg_wr_addr == CFG_AW'(2 * ENTRIES + 1);

  rxaf_addr_capture #(.BYTES(ADDR_BYTES)) cap_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_start(da_start),
    .da_byte(da_byte), .last_byte(last_byte), .full_addr(cur_addr));

  rxaf_exact_bank #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(ent_wr), .wr_entry(cfg_wr_addr[EIW:1]),
    .wr_hi(cfg_wr_addr[0]), .wr_data(cfg_wr_data), .look_addr(cur_addr),
    .hit(exact_hit));

  rxaf_hash_table hash_i (
    .clk(clk), .rst_n(rst_n), .wr_lo(hash_wr_lo), .wr_hi(hash_wr_hi),
    .wr_data(cfg_wr_data), .look_addr(cur_addr), .bin(bin), .bin_set(bin_set));

  assign is_b = is_all_ones(cur_addr);
  assign is_m = is_group(cur_addr);

  assign why_copy  = ctl_copy_all;
  assign why_exact = exact_hit;
  assign why_bcast = is_b && !ctl_bcast_dis;
  assign why_hash  = is_m && !is_b && ctl_hash_en && bin_set;
  assign accept_c  = why_copy || why_exact || why_bcast || why_hash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid  <= last_byte;
      verdict_accept <= last_byte && accept_c;
    end
  end

  AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> verdict_valid); // R2
  AST_VERDICT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(last_byte)); // R2
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_accept |-> verdict_valid); // R2
  AST_COPY_ALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && ctl_copy_all) |=> verdict_accept); // R3
  AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && is_b && ctl_bcast_dis && !ctl_copy_all && !exact_hit)
      |=> !verdict_accept); // R8
  AST_UCAST_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !is_m && !ctl_copy_all && !exact_hit) |=> !verdict_accept); // R9
  AST_HASH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !is_b && !ctl_hash_en && !ctl_copy_all && !exact_hit)
      |=> !verdict_accept); // R7
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        ctl_copy_all = 1'b0, ctl_hash_en = 1'b0, ctl_bcast_dis = 1'b0;
  logic        da_valid = 1'b0, da_start = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        verdict_valid, verdict_accept;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // reference state
  logic [7:0]  mb [6];
  int          mcnt = 0;
  logic [31:0] m_lo [8];
  logic [15:0] m_hi [8];
  bit          m_v  [8];
  logic [63:0] m_hash = '0;
  bit          last_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .ctl_copy_all(ctl_copy_all), .ctl_hash_en(ctl_hash_en),
    .ctl_bcast_dis(ctl_bcast_dis), .da_valid(da_valid), .da_start(da_start),
    .da_byte(da_byte), .verdict_valid(verdict_valid), .verdict_accept(verdict_accept));

  function automatic int ref_hash(input logic [47:0] a);
    int h = 0;
    for (int n = 0; n < 48; n++) if (a[n]) h = h ^ (1 << (n % 6));
    return h;
  endfunction

  function automatic bit model_accept();
    logic [47:0] a = {mb[5], mb[4], mb[3], mb[2], mb[1], mb[0]};
    bit bc = (a == 48'hFFFF_FFFF_FFFF);
    bit ex = 0;
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_lo[i] == a[31:0] && m_hi[i] == a[47:32]) ex = 1;
    return ctl_copy_all || ex || (bc && !ctl_bcast_dis) ||
           (mb[0][0] && !bc && ctl_hash_en && m_hash[ref_hash(a)]);
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // one clock: predict, advance the model, compare after the edge
  task automatic step();
    bit ev = 0, ea = 0;
    if (da_valid) begin
      if (da_start) begin mb[0] = da_byte; mcnt = 1; end
      else if (mcnt > 0 && mcnt < 6) begin
        mb[mcnt] = da_byte; mcnt++;
        if (mcnt == 6) begin ev = 1; ea = model_accept(); end
      end
    end
    if (cfg_wr_en) begin
      if (cfg_wr_addr < 16) begin
        if (cfg_wr_addr[0]) begin m_hi[cfg_wr_addr >> 1] = cfg_wr_data[15:0]; m_v[cfg_wr_addr >> 1] = 1; end
        else m_lo[cfg_wr_addr >> 1] = cfg_wr_data;
      end else if (cfg_wr_addr == 16) m_hash[31:0] = cfg_wr_data;
      else if (cfg_wr_addr == 17) m_hash[63:32] = cfg_wr_data;
    end
    @(posedge clk); #1;
    checks++;
    if (verdict_valid !== ev || verdict_accept !== (ev & ea)) begin
      fails++;
      $display("FAIL %s: valid/accept got %0b/%0b expected %0b/%0b at %0t",
               cur_req, verdict_valid, verdict_accept, ev, ev & ea, $time);
    end
    last_acc = verdict_accept;
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d; step();
    cfg_wr_en = 0;
  endtask

  task automatic set_entry(input int k, input logic [47:0] a);
    cfg_write(5'(2*k), a[31:0]);
    cfg_write(5'(2*k+1), {16'h0, a[47:32]});
  endtask

  task automatic send_addr(input logic [47:0] a, output bit acc);
    for (int b = 0; b < 6; b++) begin
      da_valid = 1; da_start = (b == 0); da_byte = a[8*b +: 8];
      step();
      if (b == 5) acc = last_acc;
    end
    da_valid = 0; da_start = 0;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    bit acc;
    logic [47:0] ua = 48'h5544_3322_1100, ga = 48'h0000_5E00_0101;
    logic [47:0] bc = 48'hFFFF_FFFF_FFFF, ma;
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1";
    check("R1", verdict_valid, 0);
    repeat (2) step();
    ctl_hash_en = 1;
    send_addr(ua, acc); check("R1", acc, 0);
    send_addr(ga, acc); check("R1", acc, 0);
    send_addr(bc, acc); check("R1", acc, 1);

    cur_req = "R3"; ctl_copy_all = 1;
    send_addr(ua, acc); check("R3", acc, 1);
    ctl_bcast_dis = 1;
    send_addr(bc, acc); check("R3", acc, 1);
    ctl_copy_all = 0; ctl_bcast_dis = 0;

    cur_req = "R4";
    cfg_write(5'd0, ua[31:0]);
    send_addr(ua, acc); check("R4", acc, 0);
    cfg_write(5'd1, {16'h0, ua[47:32]});
    send_addr(ua, acc); check("R4", acc, 1);
    send_addr(ua ^ 48'h0100_0000_0000, acc); check("R9", acc, 0);
    for (int k = 1; k < 8; k++) set_entry(k, ga + 48'(k << 24));
    for (int k = 1; k < 8; k++) begin
      send_addr(ga + 48'(k << 24), acc); check("R4", acc, 1);
    end
    cfg_write(5'd18, 32'hFFFF_FFFF);
    cfg_write(5'd31, 32'hFFFF_FFFF);
    cur_req = "R6";
    send_addr(ga + 48'h1, acc); check("R6", acc, 0);

    cur_req = "R8"; ctl_bcast_dis = 1;
    send_addr(bc, acc); check("R8", acc, 0);
    set_entry(7, bc);
    send_addr(bc, acc); check("R8", acc, 1);
    set_entry(7, ga + 48'(7 << 24));
    ctl_bcast_dis = 0;

    cur_req = "R5";
    for (int trial = 0; trial < 12; trial++) begin
      int h;
      ma = {$urandom(), $urandom()};
      ma[0] = 1; ma[47:40] = 8'h3C;
      h = ref_hash(ma);
      cfg_write(5'd16, h < 32 ? (32'h1 << h) : 32'h0);
      cfg_write(5'd17, h >= 32 ? (32'h1 << (h - 32)) : 32'h0);
      ctl_hash_en = 1;
      send_addr(ma, acc); check("R5", acc, 1);
      send_addr(ma ^ 48'h1 << (1 + trial % 5), acc); check("R5", acc, 0);
      ctl_hash_en = 0;
      send_addr(ma, acc); check("R7", acc, 0);
      send_addr(ma & ~48'h1, acc); check("R9", acc, 0);
    end

    cur_req = "R10";
    cfg_write(5'd16, 32'hFFFF_FFFF);
    cfg_write(5'd17, 32'hFFFF_FFFF);
    ctl_hash_en = 1;
    for (int trial = 0; trial < 8; trial++) begin
      ma = {$urandom(), $urandom()}; ma[0] = 1; ma[47:40] = 8'hA5;
      send_addr(ma, acc); check("R10", acc, 1);
      ma[0] = 0;
      send_addr(ma, acc); check("R9", acc, 0);
    end
    ctl_bcast_dis = 1;
    send_addr(bc, acc); check("R7", acc, 0);
    ctl_bcast_dis = 0;

    cur_req = "R2";
    for (int b = 0; b < 3; b++) begin
      da_valid = 1; da_start = (b == 0); da_byte = 8'hEE; step();
    end
    da_valid = 0; da_start = 0; step(); step();
    send_addr(ua, acc); check("R2", acc, 1);
    for (int b = 0; b < 6; b++) begin
      da_valid = 1; da_start = (b == 0); da_byte = ua[8*b +: 8]; step();
      da_valid = 0; da_start = 0; step();
    end
    check("R2", verdict_valid, 0);

    cur_req = "R11";
    for (int b = 0; b < 4; b++) begin
      da_valid = 1; da_byte = 8'h11; step();
      check("R11", verdict_valid, 0);
    end
    da_valid = 0; step();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule